// File: doc/BRIEF.md
# Four-Channel DMA Request Priority Arbiter

This block decides which of four DMA request channels receives service next. Each channel is eligible when its request is high, its mask bit is clear and the controller-wide disable bit is clear. When any channel is eligible, the arbiter raises a hold request towards the bus owner. It then waits for hold-acknowledge. Priority is resolved in the cycle where hold-acknowledge is seen, and the winner is latched as a one-hot grant.

A grant stays fixed until a single-cycle service-done pulse arrives. Requests that change while a service runs have no effect on it. After service-done, the grant and the hold request both drop. No new hold request is raised until hold-acknowledge has been seen low for at least one clock. A mode bit selects the priority scheme:

- **Fixed order:** channel 0 is always first.
- **Rotating order:** the channel just served becomes lowest and its successor becomes highest. The rotation advances only when a service completes in rotating mode.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, grant is 0, grant_ch is 0, hold_req is 0, and the rotation state puts channel 0 highest.
- R2: With the arbiter idle, an eligible request (req[i]=1, mask[i]=0, ctrl_disable=0) raises hold_req on the next clock.
- R3: A channel whose mask bit is 1, or any channel while ctrl_disable is 1, is never granted and does not raise hold_req.
- R4: With rotate_en=0, the eligible channel with the lowest index at the hold_ack edge is granted, in the cycle after hold_ack is first seen high.
- R5: With rotate_en=1, after a service of channel k completes, the search order is k+1, k+2, and so on modulo 4, with k last.
- R6: grant is one-hot or zero, and it stays unchanged from the grant until service-done, whatever req and mask do meanwhile.
- R7: svc_done during a service clears grant and hold_req on the next clock.
- R8: After a service ends, hold_req stays 0 until hold_ack has been sampled low, even while eligible requests are present.
- R9: If no channel is eligible when hold_ack arrives, hold_req drops on the next clock and no grant is issued.
- R10: While grant is non-zero, grant_ch is the index of its set bit (grant = 1 << grant_ch).
- R11: A service completed with rotate_en=0 leaves the rotation state unchanged, and masked channels never move it.
- R12: With rotate_en=1 and all channels requesting, every channel is granted within four consecutive services.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | Per-channel DMA request |
| mask | input | 4 | Per-channel mask; 1 blocks the channel |
| rotate_en | input | 1 | 1 selects rotating order, 0 selects fixed order |
| ctrl_disable | input | 1 | 1 blocks every channel |
| hold_ack | input | 1 | Bus handed to the DMA side |
| svc_done | input | 1 | Single-cycle pulse ending the current service |
| grant | output | 4 | One-hot grant of the serviced channel |
| hold_req | output | 1 | Request for the bus |
| grant_ch | output | 2 | Binary index of the granted channel |

## Verification
Two things can happen in the same clock:

- **Service completion and a new request.** The bench asserts svc_done while every channel, including ones above the served one, is requesting. It checks that the grant still drops at once. It also checks that hold_req stays low while hold_ack lingers high.
- **Hold-acknowledge and a request withdrawal.** The bench withdraws the only request in the cycle where hold_ack rises. It then expects the hold request to fall with no grant.

A scoreboard queue of expected winners judges every grant edge. The winners are worked out from the fixed and rotating orders.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ASK   = 2'd1,
    ST_SERVE = 2'd2,
    ST_YIELD = 2'd3
  } arb_state_t;
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic [NCH-1:0] elig,
  input  logic [CW-1:0]  base,
  output logic [NCH-1:0] onehot,
  output logic [CW-1:0]  idx,
  output logic           any
);
  logic hit;
  int   cand;

  assign any = |elig;

  // Walk from the highest-priority position around the ring.
  always_comb begin
    hit    = 1'b0;
    cand   = 0;
    idx    = '0;
    onehot = '0;
    for (int i = 0; i < NCH; i++) begin
      cand = (int'(base) + i) % NCH;
      if (!hit && elig[cand]) begin
        hit          = 1'b1;
        idx          = CW'(cand);
        onehot[cand] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_rot_ptr.sv
module arb_rot_ptr #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          rotate_en,
  input  logic [CW-1:0] served_ch,
  output logic [CW-1:0] ptr
);
  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  logic [CW-1:0] next_top;

  assign next_top = (served_ch == LAST) ? '0 : served_ch + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv && rotate_en) begin
      ptr <= next_top;
    end
  end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_elig,
  input  logic           hold_ack,
  input  logic           svc_done,
  input  logic [NCH-1:0] pick_onehot,
  input  logic [CW-1:0]  pick_idx,
  output logic [NCH-1:0] grant,
  output logic [CW-1:0]  grant_ch,
  output logic           hold_req,
  output logic           adv
);
  arb_state_t state;

  assign hold_req = (state == ST_ASK) || (state == ST_SERVE);
  assign adv      = (state == ST_SERVE) && svc_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      grant    <= '0;
      grant_ch <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (any_elig) state <= ST_ASK;
        end
        ST_ASK: begin
          if (hold_ack) begin
            if (any_elig) begin
              state    <= ST_SERVE;
              grant    <= pick_onehot;
              grant_ch <= pick_idx;
            end else begin
              state <= ST_YIELD;
            end
          end
        end
        ST_SERVE: begin
          if (svc_done) begin
            state <= ST_YIELD;
            grant <= '0;
          end
        end
        ST_YIELD: begin
          if (!hold_ack) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] mask,
  input  logic           rotate_en,
  input  logic           ctrl_disable,
  input  logic           hold_ack,
  input  logic           svc_done,
  output logic [NCH-1:0] grant,
  output logic           hold_req,
  output logic [CW-1:0]  grant_ch
);
  logic [NCH-1:0] elig;
  logic [NCH-1:0] pick_onehot;
  logic [CW-1:0]  pick_idx;
  logic [CW-1:0]  ptr;
  logic [CW-1:0]  base;
  logic           any_elig;
  logic           adv;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign elig[g] = req[g] & ~mask[g] & ~ctrl_disable;
  end

  assign base = rotate_en ? ptr : '0;

  arb_pick #(.NCH(NCH), .CW(CW)) u_pick (
    .elig   (elig),
    .base   (base),
    .onehot (pick_onehot),
    .idx    (pick_idx),
    .any    (any_elig)
  );

  arb_rot_ptr #(.NCH(NCH), .CW(CW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .rotate_en (rotate_en),
    .served_ch (grant_ch),
    .ptr       (ptr)
  );

  arb_ctrl #(.NCH(NCH), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_elig    (any_elig),
    .hold_ack    (hold_ack),
    .svc_done    (svc_done),
    .pick_onehot (pick_onehot),
    .pick_idx    (pick_idx),
    .grant       (grant),
    .grant_ch    (grant_ch),
    .hold_req    (hold_req),
    .adv         (adv)
  );
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] mask,
  input logic           ctrl_disable,
  input logic           hold_ack,
  input logic           svc_done,
  input logic [NCH-1:0] grant,
  input logic           hold_req,
  input logic [CW-1:0]  grant_ch
);
  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6
  grant_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !svc_done) |=> $stable(grant));

  // R6
  grant_has_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> hold_req);

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && svc_done) |=> (grant == '0 && !hold_req));

  // R3
  masked_never_won_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && $past(grant) == '0) |-> ((grant & $past(mask)) == '0 && !$past(ctrl_disable)));

  // R9
  empty_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && grant == '0 && hold_ack && (((req & ~mask) == '0) || ctrl_disable))
      |=> (!hold_req && grant == '0));

  // R10
  index_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> grant[grant_ch]);
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req          (req),
  .mask         (mask),
  .ctrl_disable (ctrl_disable),
  .hold_ack     (hold_ack),
  .svc_done     (svc_done),
  .grant        (grant),
  .hold_req     (hold_req),
  .grant_ch     (grant_ch)
);

// File: tb/test_dma_prio_arb.sv
module test_dma_prio_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] mask = '0;
  logic       rotate_en = 1'b0;
  logic       ctrl_disable = 1'b0;
  logic       hold_ack = 1'b0;
  logic       svc_done = 1'b0;
  logic [3:0] grant;
  logic       hold_req;
  logic [1:0] grant_ch;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int exp_q[$];
  logic [3:0] prev_grant = '0;

  always #4 clk = ~clk;

  dma_prio_arb i_dma_prio_arb (
    .clk (clk), .rst_n (rst_n), .req (req), .mask (mask),
    .rotate_en (rotate_en), .ctrl_disable (ctrl_disable),
    .hold_ack (hold_ack), .svc_done (svc_done),
    .grant (grant), .hold_req (hold_req), .grant_ch (grant_ch)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: every new grant is compared with the next scoreboard entry.
  always @(negedge clk) begin
    if (rst_n && grant != '0 && prev_grant == '0) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected grant", int'(grant), 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(grant_ch == 2'(e), "R4/R5 winner (grant_ch, R10)", int'(grant_ch), e);
        chk(grant == 4'(1 << e), "R10 onehot grant", int'(grant), 1 << e);
      end
    end
    prev_grant = grant;
  end

  // Driver: one complete service with the expected winner pushed first.
  task automatic service(input logic [3:0] r, input logic [3:0] m, input bit rot, input int exp);
    @(negedge clk);
    req = r; mask = m; rotate_en = rot;
    exp_q.push_back(exp);
    @(negedge clk);
    chk(hold_req == 1'b1, "R2 hold_req raised", int'(hold_req), 1);
    hold_ack = 1'b1;
    @(negedge clk);
    req = 4'b1111; mask = 4'b0000;
    repeat (2) @(negedge clk);
    chk(grant == 4'(1 << exp), "R6 grant held", int'(grant), 1 << exp);
    svc_done = 1'b1;
    @(negedge clk);
    svc_done = 1'b0;
    chk(grant == 4'b0000 && hold_req == 1'b0, "R7 release", int'({hold_req, grant}), 0);
    @(negedge clk);
    chk(hold_req == 1'b0, "R8 waits for hold_ack low", int'(hold_req), 0);
    hold_ack = 1'b0; req = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(grant == '0 && hold_req == 1'b0 && grant_ch == '0, "R1 reset state",
        int'({hold_req, grant_ch, grant}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Fixed order
    service(4'b1111, 4'b0000, 1'b0, 0);   // R4
    service(4'b1100, 4'b0000, 1'b0, 2);   // R4
    service(4'b1010, 4'b0010, 1'b0, 3);   // R3 mask skips ch1

    // R3: disable and full mask block hold_req
    @(negedge clk); ctrl_disable = 1'b1; req = 4'b1111;
    repeat (3) @(negedge clk);
    chk(hold_req == 1'b0, "R3 ctrl_disable blocks", int'(hold_req), 0);
    ctrl_disable = 1'b0; mask = 4'b1111;
    repeat (3) @(negedge clk);
    chk(hold_req == 1'b0, "R3 mask blocks", int'(hold_req), 0);
    req = '0; mask = '0;
    @(negedge clk);

    // R9: request withdrawn in the hold_ack cycle
    req = 4'b0010;
    @(negedge clk);
    chk(hold_req == 1'b1, "R2 hold_req for R9 case", int'(hold_req), 1);
    req = '0; hold_ack = 1'b1;
    @(negedge clk);
    chk(hold_req == 1'b0 && grant == '0, "R9 empty ack", int'({hold_req, grant}), 0);
    hold_ack = 1'b0;
    repeat (2) @(negedge clk);

    // Rotating order; R1 pointer starts at channel 0, R12 all four within four
    service(4'b1111, 4'b0000, 1'b1, 0);
    service(4'b1111, 4'b0000, 1'b1, 1);   // R5
    service(4'b1111, 4'b0000, 1'b1, 2);   // R5
    service(4'b1111, 4'b0000, 1'b1, 3);   // R12
    service(4'b1001, 4'b0000, 1'b1, 0);   // R5 wrap
    service(4'b1001, 4'b0000, 1'b1, 3);   // R5 order 1,2,3,0
    // R11: fixed-mode service leaves rotation at channel 0 first
    service(4'b0100, 4'b0000, 1'b0, 2);
    service(4'b1110, 4'b0010, 1'b1, 2);   // R11 pointer still 0, ch1 masked
    service(4'b0011, 4'b0000, 1'b1, 0);   // R5 order 3,0,1,2

    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule